// File: doc/BRIEF.md
# Eleven-Input Mixed-Weight Column Counter Row

This block reduces eleven binary operands to four. Each bit column holds a counter cell that takes seven bits of weight one and four bits of weight two and returns the four-bit binary value of their weighted sum. That sum is at most 7 + 2*4 = 15, so it fits exactly in four bits. The cell is written only with two-input AND-type gates: AND, OR, their inverted forms, and gates with inverted inputs. It uses no exclusive-or anywhere, including for the low output bit, which is a parity.

Inside the cell, the weight-one bits are split into a group of three and a group of four. Each group, and the group of weight-two bits, is turned into a one-hot "count equals k" vector by a chain of AND/OR stages. The vectors are then merged by AND/OR convolution into one-hot counts of partial sums. Each output bit is an OR over the count values in which that bit is set. The cell has no clock, no state and no reset.

The row wrapper places one cell per column for a parameter width W. It spreads the four cell outputs into four result operands shifted by 0, 1, 2 and 3 places. The four result operands, added together, equal the sum of the seven weight-one operands plus twice the sum of the four weight-two operands. A later carry-save or carry-propagate stage consumes them.

Top module: `count15_row`

## Requirements
- R1: For every column i, the four bits {out3[i+3], out2[i+2], out1[i+1], out0[i]} (weights 8, 4, 2, 1) equal the number of set bits among the seven weight-one bits of column i plus twice the number of set bits among its four weight-two bits.
- R2: out0[i] is 1 exactly when an odd number (1, 3, 5 or 7) of the seven weight-one bits of column i are set, whatever the weight-two bits are.
- R3: A column whose eleven inputs are all zero gives 0. A column whose eleven inputs are all one gives 15, with all four output bits set.
- R4: Bits that carry no cell output are always zero: out0[W+2:W], out1[0], out1[W+2:W+1], out2[1:0], out2[W+2], and out3[2:0].
- R5: Taken as unsigned numbers, out0 + out1 + out2 + out3 equals the sum of the seven W-bit operands in p_in plus twice the sum of the four W-bit operands in q_in. Operand j of p_in is p_in[j*W +: W], and operand j of q_in is q_in[j*W +: W].
- R6: Within each weight class the inputs are interchangeable. Permuting the seven weight-one bits of a column, or the four weight-two bits, leaves the outputs unchanged.
- R7: Columns are independent. The outputs of column i depend only on bit i of each operand.
- R8: The block is purely combinational. The outputs follow a change of input within the same time step, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| p_in | input | 7*W | Seven weight-one operands; operand j at bits [j*W +: W] |
| q_in | input | 4*W | Four weight-two operands; operand j at bits [j*W +: W] |
| out0 | output | W+3 | Result operand carrying cell bit 0 of column i at bit i |
| out1 | output | W+3 | Result operand carrying cell bit 1 of column i at bit i+1 |
| out2 | output | W+3 | Result operand carrying cell bit 2 of column i at bit i+2 |
| out3 | output | W+3 | Result operand carrying cell bit 3 of column i at bit i+3 |

## Verification
A single-column instance is swept over all 2048 input patterns. This separates a wrong sum value from a wrong parity bit and from bits leaking into unused positions. It also includes the all-zero and all-one extremes. Rotated copies of patterns are compared with the originals, so that a cell treating one input position differently from the others shows up even where the total is right. A four-column instance is driven with pseudo-random operands and with single-column patterns. These are checked per column and on the recombined total, which exposes crossed columns and wrong output shifts.

// File: rtl/count15_pkg.sv
package count15_pkg;
    localparam int LO_N   = 7;               // weight-one inputs per column
    localparam int HI_N   = 4;               // weight-two inputs per column
    localparam int GRP_A  = 3;               // first weight-one group
    localparam int GRP_B  = LO_N - GRP_A;    // second weight-one group
    localparam int HALF_N = LO_N / 2;        // largest value of (weight-one sum) >> 1
    localparam int PART_N = HALF_N + HI_N;   // largest value of the upper part
    localparam int SUM_W  = 4;               // result bits per column
    typedef logic [SUM_W-1:0] colsum_t;
endpackage

// File: rtl/cnt_onehot.sv
// One-hot population count built from AND/OR stages only.
// hot[k] is 1 exactly when k of the N input bits are set.
module cnt_onehot #(
    parameter int N = 4
) (
    input  logic [N-1:0] bits,
    output logic [N:0]   hot
);
    logic [N:0] acc;

    always_comb begin
        acc    = '0;
        acc[0] = 1'b1;
        for (int i = 0; i < N; i++) begin
            // walk downward so each stage reads the previous stage's value
            for (int k = N; k >= 1; k--) begin
                acc[k] = (acc[k] & ~bits[i]) | (acc[k-1] & bits[i]);
            end
            acc[0] = acc[0] & ~bits[i];
        end
        hot = acc;
    end
endmodule

// File: rtl/onehot_add.sv
// Adds two one-hot counts, giving the one-hot count of their sum (AND/OR only).
module onehot_add #(
    parameter int NA = 3,
    parameter int NB = 4
) (
    input  logic [NA:0]    a,
    input  logic [NB:0]    b,
    output logic [NA+NB:0] s
);
    always_comb begin
        s = '0;
        for (int i = 0; i <= NA; i++) begin
            for (int j = 0; j <= NB; j++) begin
                s[i+j] = s[i+j] | (a[i] & b[j]);
            end
        end
    end
endmodule

// File: rtl/count15_cell.sv
// One column: seven weight-one bits plus four weight-two bits -> 4-bit sum.
module count15_cell
    import count15_pkg::*;
(
    input  logic [LO_N-1:0] lo,
    input  logic [HI_N-1:0] hi,
    output colsum_t         y
);
    logic [GRP_A:0]  cnt_a;   // one-hot count of lo[2:0]
    logic [GRP_B:0]  cnt_b;   // one-hot count of lo[6:3]
    logic [HI_N:0]   cnt_h;   // one-hot count of hi
    logic [LO_N:0]   sum_lo;  // one-hot weight-one total
    logic [HALF_N:0] half_lo; // one-hot of weight-one total >> 1
    logic [PART_N:0] upper;   // one-hot of (weight-one total >> 1) + weight-two count

    cnt_onehot #(.N(GRP_A)) u_grp_a (.bits(lo[GRP_A-1:0]),    .hot(cnt_a));
    cnt_onehot #(.N(GRP_B)) u_grp_b (.bits(lo[LO_N-1:GRP_A]), .hot(cnt_b));
    cnt_onehot #(.N(HI_N))  u_grp_h (.bits(hi),               .hot(cnt_h));

    onehot_add #(.NA(GRP_A), .NB(GRP_B)) u_lo_add (
        .a(cnt_a), .b(cnt_b), .s(sum_lo)
    );

    // fold pairs of the weight-one total to drop its lowest bit
    generate
        for (genvar j = 0; j <= HALF_N; j++) begin : g_half
            if (2*j + 1 <= LO_N) begin : g_pair
                assign half_lo[j] = sum_lo[2*j] | sum_lo[2*j+1];
            end else begin : g_single
                assign half_lo[j] = sum_lo[2*j];
            end
        end
    endgenerate

    onehot_add #(.NA(HALF_N), .NB(HI_N)) u_up_add (
        .a(half_lo), .b(cnt_h), .s(upper)
    );

    // each output bit is the OR of the count indicators in which it is set
    always_comb begin
        y = '0;
        for (int n = 1; n <= LO_N; n += 2) begin
            y[0] = y[0] | sum_lo[n];
        end
        for (int k = 1; k < SUM_W; k++) begin
            for (int n = 0; n <= PART_N; n++) begin
                if (((n >> (k-1)) % 2) == 1) begin
                    y[k] = y[k] | upper[n];
                end
            end
        end
    end
endmodule

// File: rtl/count15_row.sv
// Row of per-column counters reducing eleven operands to four.
module count15_row
    import count15_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [LO_N*W-1:0] p_in,
    input  logic [HI_N*W-1:0] q_in,
    output logic [W+2:0]      out0,
    output logic [W+2:0]      out1,
    output logic [W+2:0]      out2,
    output logic [W+2:0]      out3
);
    colsum_t col_y [W];

    generate
        for (genvar c = 0; c < W; c++) begin : g_col
            logic [LO_N-1:0] lo_bits;
            logic [HI_N-1:0] hi_bits;
            for (genvar j = 0; j < LO_N; j++) begin : g_lo
                assign lo_bits[j] = p_in[j*W + c];
            end
            for (genvar j = 0; j < HI_N; j++) begin : g_hi
                assign hi_bits[j] = q_in[j*W + c];
            end
            count15_cell u_cell (.lo(lo_bits), .hi(hi_bits), .y(col_y[c]));
        end
    endgenerate

    always_comb begin
        out0 = '0;
        out1 = '0;
        out2 = '0;
        out3 = '0;
        for (int c = 0; c < W; c++) begin
            out0[c]   = col_y[c][0];
            out1[c+1] = col_y[c][1];
            out2[c+2] = col_y[c][2];
            out3[c+3] = col_y[c][3];
        end
    end
endmodule

// File: rtl/count15_row_chk.sv
module count15_row_chk #(
    parameter int W = 8
) (
    input logic [7*W-1:0] p_in,
    input logic [4*W-1:0] q_in,
    input logic [W+2:0]   out0,
    input logic [W+2:0]   out1,
    input logic [W+2:0]   out2,
    input logic [W+2:0]   out3
);
    always_comb begin
        // R4
        spare_bits_zero_chk: assert (out0[W+2:W] == 3'b000 && out1[0] == 1'b0 &&
                                     out1[W+2:W+1] == 2'b00 && out2[1:0] == 2'b00 &&
                                     out2[W+2] == 1'b0 && out3[2:0] == 3'b000);
        for (int c = 0; c < W; c++) begin
            automatic int lc = 0;
            automatic int hc = 0;
            for (int j = 0; j < 7; j++) lc += int'(p_in[j*W + c]);
            for (int j = 0; j < 4; j++) hc += int'(q_in[j*W + c]);
            // R1
            col_sum_chk: assert ({out3[c+3], out2[c+2], out1[c+1], out0[c]} == 4'(lc + 2*hc));
            // R2
            lo_parity_chk: assert (out0[c] == ((lc % 2) == 1));
            // R3
            full_column_chk: assert (!(lc == 7 && hc == 4) ||
                                     (out0[c] && out1[c+1] && out2[c+2] && out3[c+3]));
            // R3
            empty_column_chk: assert ((lc + hc) != 0 ||
                                      !(out0[c] || out1[c+1] || out2[c+2] || out3[c+3]));
        end
    end
endmodule

bind count15_row count15_row_chk #(.W(W)) u_row_chk (
    .p_in(p_in), .q_in(q_in), .out0(out0), .out1(out1), .out2(out2), .out3(out3)
);

// File: tb/count15_row_test.sv
`timescale 1ns/1ps
module count15_row_test;
    localparam int WW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [6:0]      p1;
    logic [3:0]      q1;
    logic [3:0]      o10, o11, o12, o13;
    logic [7*WW-1:0] pw;
    logic [4*WW-1:0] qw;
    logic [WW+2:0]   ow0, ow1, ow2, ow3;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    count15_row #(.W(1))  uut      (.p_in(p1), .q_in(q1), .out0(o10), .out1(o11), .out2(o12), .out3(o13));
    count15_row #(.W(WW)) uut_wide (.p_in(pw), .q_in(qw), .out0(ow0), .out1(ow1), .out2(ow2), .out3(ow3));

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int cell_val();
        return int'(o10[0]) + 2*int'(o11[1]) + 4*int'(o12[2]) + 8*int'(o13[3]);
    endfunction

    task automatic apply1(input logic [6:0] p, input logic [3:0] q);
        @(negedge clk);
        p1 = p;
        q1 = q;
        #2;
    endtask

    task automatic apply_w(input logic [7*WW-1:0] p, input logic [4*WW-1:0] q);
        @(negedge clk);
        pw = p;
        qw = q;
        #2;
    endtask

    task automatic check_wide(input string tag);
        int exp_total;
        int got_total;
        exp_total = 0;
        for (int j = 0; j < 7; j++) exp_total += int'(pw[j*WW +: WW]);
        for (int j = 0; j < 4; j++) exp_total += 2*int'(qw[j*WW +: WW]);
        got_total = int'(ow0) + int'(ow1) + int'(ow2) + int'(ow3);
        check({"R5 ", tag}, got_total, exp_total);
        for (int c = 0; c < WW; c++) begin
            int lc;
            int hc;
            lc = 0;
            hc = 0;
            for (int j = 0; j < 7; j++) lc += int'(pw[j*WW + c]);
            for (int j = 0; j < 4; j++) hc += int'(qw[j*WW + c]);
            // R7: each column from its own bits only
            check({"R7 ", tag},
                  int'(ow0[c]) + 2*int'(ow1[c+1]) + 4*int'(ow2[c+2]) + 8*int'(ow3[c+3]),
                  lc + 2*hc);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired got 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        p1 = '0; q1 = '0; pw = '0; qw = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R3: all-zero inputs give a zero result
        apply1(7'h00, 4'h0);
        check("R3 zero column", cell_val(), 0);
        apply_w('0, '0);
        check("R3 zero row", int'(ow0 | ow1 | ow2 | ow3), 0);

        // R1 R2 R4: exhaustive sweep of one column
        for (int v = 0; v < 2048; v++) begin
            logic [10:0] pat;
            int          lc;
            int          hc;
            pat = 11'(v);
            lc = $countones(pat[6:0]);
            hc = $countones(pat[10:7]);
            apply1(pat[6:0], pat[10:7]);
            check("R1 weighted sum", cell_val(), lc + 2*hc);
            check("R2 parity", int'(o10[0]), lc % 2);
            check("R4 spare bits", int'({o10[3:1], o11[0], o11[3:2], o12[1:0], o12[3], o13[2:0]}), 0);
        end

        // R3: full column gives 15
        apply1(7'h7F, 4'hF);
        check("R3 full column", cell_val(), 15);

        // R8: output follows input change with no clock edge in between
        @(negedge clk);
        p1 = 7'h05; q1 = 4'h1;
        #1;
        check("R8 immediate update a", cell_val(), 4);
        p1 = 7'h07; q1 = 4'h3;
        #1;
        check("R8 immediate update b", cell_val(), 7);

        // R6: rotations of each class leave the result unchanged
        for (int v = 0; v < 2048; v += 37) begin
            logic [10:0] pat;
            int          ref_val;
            pat = 11'(v);
            apply1(pat[6:0], pat[10:7]);
            ref_val = cell_val();
            for (int r = 1; r < 7; r++) begin
                logic [13:0] dbl;
                dbl = {pat[6:0], pat[6:0]};
                apply1(dbl[r +: 7], {pat[7], pat[10:8]});
                check("R6 permuted inputs", cell_val(), ref_val);
            end
        end

        // R5 R7: single busy column, then pseudo-random operands
        for (int c = 0; c < WW; c++) begin
            logic [7*WW-1:0] p;
            logic [4*WW-1:0] q;
            p = '0;
            q = '0;
            for (int j = 0; j < 7; j++) p[j*WW + c] = 1'b1;
            for (int j = 0; j < 4; j++) q[j*WW + c] = 1'b1;
            apply_w(p, q);
            check_wide("single column");
        end
        for (int k = 0; k < 400; k++) begin
            apply_w(28'($urandom), 16'($urandom));
            check_wide("random operands");
        end
        apply_w('1, '1);
        check_wide("all ones");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule